// File: doc/BRIEF.md
# Ten-to-Eight-Bit Character Decoder with Status and Parity

The block takes one framed 10-bit transmission character per clock, qualified by a valid strobe, and turns it into an 8-bit character value, a 3-bit status code and an odd parity bit. It keeps a running-disparity state across characters. It uses that state to detect characters sent with the wrong polarity, and it also detects bit patterns that no legal character produces.

A 2-bit mode input selects one of three behaviours. Raw mode passes the 10 received bits to the output unchanged. Primary decode reports special characters by their natural 8-bit value. Alternate decode does the same except for the four non-comma special characters ending in sub-code 7, which get a compact code of their own. All outputs are registered, and each result appears one clock after its strobe.

Top module: `sym10_decoder`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` was sampled high. After reset `out_valid` is 0 and `out_status` is 000.
- R2: A legal data character in a decode mode (mode 01 or 10) gives status 000, with `out_data[7:5]` holding the 3-bit sub-code (HGF) and `out_data[4:0]` the 5-bit sub-code (EDCBA), and `out_data[9:8]` at 0. `in_code[9:4]` is the six-bit sub-block abcdei and `in_code[3:0]` the four-bit sub-block fghj, with a and f in the most significant positions.
- R3: A legal special character other than K28.1, K28.5 and K28.7 gives status 001. In primary mode (01) its value is reported as {y, x}, for example 8'h1C for K28.0 and 8'hF7 for K23.7.
- R4: The comma-bearing characters K28.1, K28.5 and K28.7 give status 010 with value 8'h3C, 8'hBC and 8'hFC.
- R5: A character with no legal decoding gives status 100 and `out_data` 0. This covers a six-bit block that is no legal code, a four-bit block of 0000 or 1111, the alternate 7 sub-code on a data character that never uses it, and the K28 block followed by the primary 7 form.
- R6: A character whose sub-blocks violate the current running disparity gives status 101 together with its decoded value. Legality is judged from the disparity before each sub-block: a block with more ones needs negative disparity, a block with more zeros needs positive, 111000 and 1100 need negative, and 000111 and 0011 need positive.
- R7: Running disparity is negative after reset.
- R8: In raw mode (00), `out_data` equals the received 10 bits and the status is 000. Raw characters leave the running disparity unchanged.
- R9: In alternate mode (10), K23.7, K27.7, K29.7 and K30.7 are reported as 8'hF8, 8'hF9, 8'hFA and 8'hFB. Every K28 character and every data character reports the same value as in primary mode.
- R10: `out_parity` makes the number of ones across `out_data[9:0]` and `out_parity` odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A character is presented this cycle |
| in_code | input | 10 | Framed character, abcdei in [9:4], fghj in [3:0] |
| mode | input | 2 | 00 raw, 01 primary decode, 10 alternate decode, 11 as 01 |
| out_valid | output | 1 | Registered result is new this cycle |
| out_data | output | 10 | Raw bits or zero-extended decoded value |
| out_status | output | 3 | 000 data, 001 special, 010 comma, 100 invalid, 101 disparity error |
| out_parity | output | 1 | Odd parity over out_data |

## Verification
Every result (value, status, parity and the valid flag) is due exactly one clock after the edge that samples its strobe. The bench drives each character at a falling edge and reads the result at the next falling edge, which lies after that single register. Running disparity is a second, hidden register that only shows up in the status of the following character. For that reason, each test of disparity state sends a conditioning character and then a probe character, and judges the probe's status one cycle later. Between tests, the bench's own disparity model is restarted by a reset.

// File: rtl/sym10_pkg.sv
package sym10_pkg;
  localparam int CODE_W = 10;
  localparam int BYTE_W = 8;
  localparam int HI_W   = 6;
  localparam int LO_W   = 4;
  localparam int XV_W   = 5;
  localparam int YV_W   = 3;

  typedef enum logic [2:0] {
    ST_DATA  = 3'b000,
    ST_SPEC  = 3'b001,
    ST_COMMA = 3'b010,
    ST_BAD   = 3'b100,
    ST_RDERR = 3'b101
  } status_e;

  typedef enum logic [1:0] {
    MD_RAW = 2'b00,
    MD_PRI = 2'b01,
    MD_ALT = 2'b10,
    MD_RSV = 2'b11
  } mode_e;

  // six-bit block sent while disparity is negative, a in bit 5
  function automatic logic [HI_W-1:0] hi_neg(input logic [XV_W-1:0] x);
    case (x)
      5'd0:  hi_neg = 6'b100111;  5'd1:  hi_neg = 6'b011101;
      5'd2:  hi_neg = 6'b101101;  5'd3:  hi_neg = 6'b110001;
      5'd4:  hi_neg = 6'b110101;  5'd5:  hi_neg = 6'b101001;
      5'd6:  hi_neg = 6'b011001;  5'd7:  hi_neg = 6'b111000;
      5'd8:  hi_neg = 6'b111001;  5'd9:  hi_neg = 6'b100101;
      5'd10: hi_neg = 6'b010101;  5'd11: hi_neg = 6'b110100;
      5'd12: hi_neg = 6'b001101;  5'd13: hi_neg = 6'b101100;
      5'd14: hi_neg = 6'b011100;  5'd15: hi_neg = 6'b010111;
      5'd16: hi_neg = 6'b011011;  5'd17: hi_neg = 6'b100011;
      5'd18: hi_neg = 6'b010011;  5'd19: hi_neg = 6'b110010;
      5'd20: hi_neg = 6'b001011;  5'd21: hi_neg = 6'b101010;
      5'd22: hi_neg = 6'b011010;  5'd23: hi_neg = 6'b111010;
      5'd24: hi_neg = 6'b110011;  5'd25: hi_neg = 6'b100110;
      5'd26: hi_neg = 6'b010110;  5'd27: hi_neg = 6'b110110;
      5'd28: hi_neg = 6'b001110;  5'd29: hi_neg = 6'b101110;
      5'd30: hi_neg = 6'b011110;  default: hi_neg = 6'b101011;
    endcase
  endfunction

  // positive-disparity form: complement when unbalanced, and for x = 7
  function automatic logic [HI_W-1:0] hi_pos(input logic [XV_W-1:0] x);
    logic [HI_W-1:0] c;
    c = hi_neg(x);
    hi_pos = ($countones(c) != 3 || x == 5'd7) ? ~c : c;
  endfunction

  function automatic logic odd_par(input logic [CODE_W-1:0] v);
    odd_par = ~^v;
  endfunction

  // data values whose 3-bit sub-code 7 may use the alternate form
  function automatic logic alt7_data_ok(input logic [XV_W-1:0] x);
    alt7_data_ok = (x == 5'd11) || (x == 5'd13) || (x == 5'd14) ||
                   (x == 5'd17) || (x == 5'd18) || (x == 5'd20);
  endfunction

  function automatic logic is_kx7(input logic [XV_W-1:0] x);
    is_kx7 = (x == 5'd23) || (x == 5'd27) || (x == 5'd29) || (x == 5'd30);
  endfunction

  function automatic logic [BYTE_W-1:0] alt_code(input logic [XV_W-1:0] x);
    case (x)
      5'd23:   alt_code = 8'hF8;
      5'd27:   alt_code = 8'hF9;
      5'd29:   alt_code = 8'hFA;
      default: alt_code = 8'hFB;
    endcase
  endfunction
endpackage

// File: rtl/sym10_hi_dec.sv
module sym10_hi_dec
  import sym10_pkg::*;
(
  input  logic [HI_W-1:0] blk,
  output logic            hit,
  output logic            k28,
  output logic [XV_W-1:0] xval
);
  always_comb begin
    hit  = 1'b0;
    xval = '0;
    k28  = (blk == 6'b001111) || (blk == 6'b110000);
    for (int v = 0; v < 32; v++) begin
      if (blk == hi_neg(5'(v)) || blk == hi_pos(5'(v))) begin
        hit  = 1'b1;
        xval = 5'(v);
      end
    end
    if (k28) begin
      hit  = 1'b1;
      xval = 5'd28;
    end
  end
endmodule

// File: rtl/sym10_lo_dec.sv
module sym10_lo_dec
  import sym10_pkg::*;
(
  input  logic [LO_W-1:0] blk,
  output logic            hit,
  output logic            p7,
  output logic            a7,
  output logic [YV_W-1:0] yval
);
  always_comb begin
    hit  = 1'b1;
    p7   = 1'b0;
    a7   = 1'b0;
    yval = '0;
    case (blk)
      4'b1011, 4'b0100: yval = 3'd0;
      4'b1001:          yval = 3'd1;
      4'b0101:          yval = 3'd2;
      4'b1100, 4'b0011: yval = 3'd3;
      4'b1101, 4'b0010: yval = 3'd4;
      4'b1010:          yval = 3'd5;
      4'b0110:          yval = 3'd6;
      4'b1110, 4'b0001: begin yval = 3'd7; p7 = 1'b1; end
      4'b0111, 4'b1000: begin yval = 3'd7; a7 = 1'b1; end
      default:          hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/sym10_rd_chk.sv
module sym10_rd_chk
  import sym10_pkg::*;
(
  input  logic            rd_in,
  input  logic [HI_W-1:0] hi,
  input  logic [LO_W-1:0] lo,
  output logic            err,
  output logic            rd_out
);
  int   w_hi, w_lo;
  logic rd_mid;
  always_comb begin
    w_hi = $countones(hi);
    w_lo = $countones(lo);
    err  = 1'b0;
    rd_mid = rd_in;
    if (w_hi > 3) begin
      err    = rd_in;
      rd_mid = 1'b1;
    end else if (w_hi < 3) begin
      err    = ~rd_in;
      rd_mid = 1'b0;
    end else if (hi == 6'b111000) begin
      err = rd_in;
    end else if (hi == 6'b000111) begin
      err = ~rd_in;
    end
    rd_out = rd_mid;
    if (w_lo > 2) begin
      err    = err | rd_mid;
      rd_out = 1'b1;
    end else if (w_lo < 2) begin
      err    = err | ~rd_mid;
      rd_out = 1'b0;
    end else if (lo == 4'b1100) begin
      err = err | rd_mid;
    end else if (lo == 4'b0011) begin
      err = err | ~rd_mid;
    end
  end
endmodule

// File: rtl/sym10_decoder.sv
module sym10_decoder
  import sym10_pkg::*;
#(
  parameter logic RD_INIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  input  logic [1:0]        mode,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_data,
  output logic [2:0]        out_status,
  output logic              out_parity
);
  mode_e           md;
  logic [HI_W-1:0] hi;
  logic [LO_W-1:0] lo, lo_norm;
  logic            hi_hit, k28, lo_hit, p7, a7;
  logic [XV_W-1:0] xv;
  logic [YV_W-1:0] yv;
  logic            rd_q, rd_nx, rd_err;
  logic            k_other, bad_code, is_comma, ev_accept;
  logic [BYTE_W-1:0] val;
  status_e         st;
  logic [CODE_W-1:0] word;

  assign md = mode_e'(mode);
  assign hi = in_code[CODE_W-1:LO_W];
  assign lo = in_code[LO_W-1:0];
  // K28 sent with positive disparity carries a complemented four-bit block
  assign lo_norm = (hi == 6'b110000) ? ~lo : lo;

  sym10_hi_dec u_hi (.blk(hi), .hit(hi_hit), .k28(k28), .xval(xv));
  sym10_lo_dec u_lo (.blk(lo_norm), .hit(lo_hit), .p7(p7), .a7(a7), .yval(yv));
  sym10_rd_chk u_rd (.rd_in(rd_q), .hi(hi), .lo(lo), .err(rd_err), .rd_out(rd_nx));

  assign k_other  = a7 && !k28 && is_kx7(xv);
  assign bad_code = !hi_hit || !lo_hit ||
                    (a7 && !k28 && !k_other && !alt7_data_ok(xv)) ||
                    (k28 && p7);
  assign is_comma = k28 && (yv == 3'd1 || yv == 3'd5 || yv == 3'd7);
  assign ev_accept = in_valid && (md != MD_RAW);

  always_comb begin
    val = {yv, xv};
    if (md == MD_ALT && k_other) val = alt_code(xv);
    if (bad_code)              st = ST_BAD;
    else if (rd_err)           st = ST_RDERR;
    else if (is_comma)         st = ST_COMMA;
    else if (k28 || k_other)   st = ST_SPEC;
    else                       st = ST_DATA;
    if (md == MD_RAW) begin
      st   = ST_DATA;
      word = in_code;
    end else if (bad_code) begin
      word = '0;
    end else begin
      word = {{(CODE_W-BYTE_W){1'b0}}, val};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q       <= RD_INIT;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_status <= ST_DATA;
      out_parity <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (ev_accept) rd_q <= rd_nx;
      if (in_valid) begin
        out_data   <= word;
        out_status <= st;
        out_parity <= odd_par(word);
      end
    end
  end
endmodule

// File: rtl/sym10_decoder_chk.sv
module sym10_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [9:0] in_code,
  input logic [1:0] mode,
  input logic       out_valid,
  input logic [9:0] out_data,
  input logic [2:0] out_status,
  input logic       out_parity,
  input logic       rd_q,
  input logic       ev_accept
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_high_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode != 2'b00) |=> out_data[9:8] == 2'b00);
  assert_comma_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_status == 3'b010) |->
      (out_data[4:0] == 5'd28 && (out_data[7:5] == 3'd1 || out_data[7:5] == 3'd5 ||
                                  out_data[7:5] == 3'd7)));
  assert_status_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_status inside {3'b000, 3'b001, 3'b010, 3'b100, 3'b101}));
  assert_invalid_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_status == 3'b100) |-> out_data == 10'd0);
  assert_raw_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b00) |=> (out_data == $past(in_code) && out_status == 3'b000));
  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_accept |=> $stable(rd_q));
  assert_odd_parity_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (^{out_data, out_parity}) == 1'b1);
endmodule

bind sym10_decoder sym10_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code), .mode(mode),
  .out_valid(out_valid), .out_data(out_data), .out_status(out_status),
  .out_parity(out_parity), .rd_q(rd_q), .ev_accept(ev_accept)
);

// File: tb/sym10_decoder_bench.sv
`timescale 1ns/1ps
module sym10_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [9:0] in_code = '0;
  logic [1:0] mode = 2'b01;
  logic       out_valid;
  logic [9:0] out_data;
  logic [2:0] out_status;
  logic       out_parity;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  tb_rd = 1'b0;   // bench model of running disparity, 1 = positive
  bit  done = 1'b0;

  always #2 clk = ~clk;

  sym10_decoder u_sym10_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code), .mode(mode),
    .out_valid(out_valid), .out_data(out_data), .out_status(out_status),
    .out_parity(out_parity)
  );

  function automatic logic [5:0] t6(input logic [4:0] x);
    logic [5:0] r [32];
    r = '{6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001,
          6'b011001, 6'b111000, 6'b111001, 6'b100101, 6'b010101, 6'b110100,
          6'b001101, 6'b101100, 6'b011100, 6'b010111, 6'b011011, 6'b100011,
          6'b010011, 6'b110010, 6'b001011, 6'b101010, 6'b011010, 6'b111010,
          6'b110011, 6'b100110, 6'b010110, 6'b110110, 6'b001110, 6'b101110,
          6'b011110, 6'b101011};
    return r[x];
  endfunction

  function automatic logic [3:0] t4(input logic [2:0] y);
    logic [3:0] r [8];
    r = '{4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010, 4'b0110, 4'b1110};
    return r[y];
  endfunction

  function automatic bit next_rd(input bit rd, input logic [3:0] ones, input int half);
    if (ones * 2 > half) return 1'b1;
    if (ones * 2 < half) return 1'b0;
    return rd;
  endfunction

  // forward encoder from the coding rules; updates tb_rd
  function automatic logic [9:0] encode(input logic [7:0] b, input bit k);
    logic [4:0] x;
    logic [2:0] y;
    logic [5:0] c6;
    logic [3:0] c4;
    bit rm;
    x = b[4:0];
    y = b[7:5];
    if (k && x == 5'd28) begin
      c6 = 6'b001111;
      if (y == 3'd7) c4 = 4'b1000;
      else if (y == 3'd0 || y == 3'd3 || y == 3'd4) c4 = ~t4(y);
      else c4 = t4(y);
      if (tb_rd) begin c6 = ~c6; c4 = ~c4; end
    end else begin
      c6 = t6(x);
      if ((($countones(c6) != 3) || x == 5'd7) && tb_rd) c6 = ~c6;
      rm = next_rd(tb_rd, 4'($countones(c6)), 6);
      if (y == 3'd7) begin
        if (k || (!rm && (x == 17 || x == 18 || x == 20)) ||
            (rm && (x == 11 || x == 13 || x == 14)))
          c4 = rm ? 4'b1000 : 4'b0111;
        else
          c4 = rm ? 4'b0001 : 4'b1110;
      end else begin
        c4 = t4(y);
        if ((($countones(c4) != 2) || y == 3'd3) && rm) c4 = ~c4;
      end
    end
    tb_rd = next_rd(next_rd(tb_rd, 4'($countones(c6)), 6), 4'($countones(c4)), 4);
    return {c6, c4};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    tb_rd = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // present one code at a falling edge; result read one clock later
  task automatic send(input logic [9:0] c, input logic [1:0] md);
    in_valid = 1'b1;
    in_code = c;
    mode = md;
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [9:0] d, input logic [2:0] s);
    check(out_valid == 1'b1, req, "valid", 16'(out_valid), 16'd1);
    check(out_data == d && out_status == s, req, "data/status",
          {3'b0, out_status, out_data}, {3'b0, s, d});
    check((^{out_data, out_parity}) == 1'b1, "R10", "parity",
          16'(out_parity), 16'(~^out_data));
  endtask

  function automatic logic [9:0] alt_val(input logic [4:0] x);
    case (x)
      5'd23: return 10'h0F8;
      5'd27: return 10'h0F9;
      5'd29: return 10'h0FA;
      default: return 10'h0FB;
    endcase
  endfunction

  task automatic xmit(input logic [7:0] b, input bit k, input logic [1:0] md,
                      input string req);
    logic [2:0] s;
    logic [9:0] d;
    d = {2'b00, b};
    if (!k) s = 3'b000;
    else if (b == 8'h3C || b == 8'hBC || b == 8'hFC) s = 3'b010;
    else s = 3'b001;
    if (k && md == 2'b10 && b[4:0] != 5'd28) d = alt_val(b[4:0]);
    send(encode(b, k), md);
    expect_out(req, d, s);
  endtask

  task automatic test_reset_R1();
    do_reset();
    check(out_valid == 1'b0, "R1", "reset valid", 16'(out_valid), 16'd0);
    check(out_status == 3'b000, "R1", "reset status", 16'(out_status), 16'd0);
  endtask

  task automatic test_data_R2();
    do_reset();
    for (int i = 0; i < 256; i++) xmit(8'(i), 1'b0, 2'b01, "R2");
    for (int i = 255; i >= 0; i -= 7) xmit(8'(i), 1'b0, 2'b01, "R2");
    idle();
    check(out_valid == 1'b0, "R1", "idle after stream", 16'(out_valid), 16'd0);
  endtask

  task automatic test_special_R3_R4();
    logic [7:0] ks [12];
    ks = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC, 8'hDC, 8'hFC,
           8'hF7, 8'hFB, 8'hFD, 8'hFE};
    do_reset();
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < 12; i++) begin
        xmit(ks[i], 1'b1, 2'b01, (i == 1 || i == 5 || i == 7) ? "R4" : "R3");
        xmit(8'h4A, 1'b0, 2'b01, "R2");
      end
    idle();
  endtask

  task automatic test_alt_R9();
    logic [7:0] ks [6];
    ks = '{8'hF7, 8'hFB, 8'hFD, 8'hFE, 8'h1C, 8'hBC};
    do_reset();
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < 6; i++) begin
        xmit(ks[i], 1'b1, 2'b10, "R9");
        xmit(8'hF7, 1'b0, 2'b10, "R9");
      end
    idle();
  endtask

  task automatic test_invalid_R5();
    do_reset();
    send(10'b000000_1010, 2'b01); expect_out("R5", 10'd0, 3'b100);
    do_reset();
    send(10'b100111_0000, 2'b01); expect_out("R5", 10'd0, 3'b100);
    do_reset();
    send(10'b001111_0001, 2'b01); expect_out("R5", 10'd0, 3'b100);
    do_reset();
    send(10'b100111_0111, 2'b01); expect_out("R5", 10'd0, 3'b100);
    idle();
  endtask

  task automatic test_disparity_R6();
    do_reset();
    send(10'b100111_1001, 2'b01); expect_out("R6", 10'h020, 3'b000);
    send(10'b100111_1001, 2'b01); expect_out("R6", 10'h020, 3'b101);
    do_reset();
    send(10'b111000_1001, 2'b01); expect_out("R6", 10'h027, 3'b000);
    send(10'b100111_1100, 2'b01); expect_out("R6", 10'h060, 3'b101);
    idle();
  endtask

  task automatic test_rd_init_R7();
    do_reset();
    send(10'b011000_1011, 2'b01); expect_out("R7", 10'h000, 3'b101);
    do_reset();
    send(10'b100111_0100, 2'b01); expect_out("R7", 10'h000, 3'b000);
    idle();
  endtask

  task automatic test_raw_R8();
    do_reset();
    send(10'h3FF, 2'b00); expect_out("R8", 10'h3FF, 3'b000);
    send(10'h001, 2'b00); expect_out("R8", 10'h001, 3'b000);
    send(10'b100111_1001, 2'b00); expect_out("R8", 10'b100111_1001, 3'b000);
    send(10'b100111_1001, 2'b01); expect_out("R8", 10'h020, 3'b000);
    idle();
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    test_reset_R1();
    test_data_R2();
    test_special_R3_R4();
    test_alt_R9();
    test_invalid_R5();
    test_disparity_R6();
    test_rd_init_R7();
    test_raw_R8();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule